// File: doc/BRIEF.md
# Audio Frame Sync Generator

This block produces the frame synchronization signal for a serial audio port that drives its own bit clock. A bit-rate tick arrives once per serial bit. On each tick the block advances a bit counter through the frame and updates its outputs. The frame sync (FS) output is shaped by four settings: the frame length, the width of the active pulse, the active polarity, and an option that moves the pulse one bit earlier than bit 0. A fifth setting turns FS into a channel marker that stays active for the whole first half of the frame.

The block also drives the current bit index, a frame-start strobe and a channel flag. The channel flag reads 0 in the first half of the frame and 1 in the second half. Software writes the settings as one 32-bit word. A write is accepted only while the block is disabled. When the enable is dropped, the outputs return to idle.

Top module: `frame_sync_gen`

## Requirements
- R1: After reset, the settings word is 0x07, which gives an 8-bit frame, a one-bit pulse, active-low FS and no early shift. The outputs are idle: FS=1, bit index 0, channel flag 0, frame-start 0.
- R2: The frame is L = max(word[7:0], 7) + 1 bits long. The bit index steps 0, 1, …, L-1 on successive ticks and then wraps to 0. A length field below 7 behaves as 7.
- R3: The first tick after the enable rises yields bit index 0. The frame-start output is 1 exactly when the bit index is 0.
- R4: Without the early shift and without the half mark, FS is active for bit indices 0 to A-1, where A = word[14:8] + 1.
- R5: word[17] picks the active level of FS: 1 means active high and 0 means active low. The inactive level is the opposite.
- R6: With word[18]=1 the active window moves one bit earlier. FS is active at bit index L-1 and at indices 0 to A-2. In the first frame after enable, no earlier bit exists, so that frame's pulse starts at index 0.
- R7: With word[16]=1, the active window is the first floor(L/2) bits of the frame and word[14:8] is ignored. The early shift still applies.
- R8: If A is at least L, FS is active for every bit of the frame and never goes inactive while running.
- R9: The channel flag is 1 exactly when the bit index is at least floor(L/2).
- R10: A settings write made while the block is enabled has no effect, even after the block is later disabled.
- R11: Between ticks all outputs hold their values. While disabled, the outputs are idle: bit index 0, FS at the inactive level, channel flag 0, frame-start 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Settings write strobe |
| cfgWrData | input | 32 | Settings word |
| enable | input | 1 | Run enable |
| bitTick | input | 1 | One-cycle pulse per serial bit |
| fsOut | output | 1 | Frame sync |
| bitIndex | output | 8 | Bit position within the frame |
| chanRight | output | 1 | 0 in first half of frame, 1 in second |
| frameStart | output | 1 | High while bit index is 0 and running |

## Verification
The assertions check these rules on every cycle:
- the counter either steps by one or wraps to zero on a tick;
- the outputs hold when no tick arrives;
- frame-start only coincides with index 0;
- the channel flag is low at index 0;
- everything is idle while disabled.

The pulse width, polarity, early shift, half-frame marking, length clamp and the rejection of writes while enabled all depend on the settings word. Only the bench scenarios can show them, by comparing every tick against a model.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int LEN_W   = 8;
  localparam int ACT_W   = 7;
  localparam int CNT_W   = LEN_W + 1;
  localparam int CFG_W   = 32;
  localparam int LEN_LSB = 0;
  localparam int ACT_LSB = 8;
  localparam int HALF_BIT = 16;
  localparam int POL_BIT  = 17;
  localparam int OFF_BIT  = 18;
  localparam logic [LEN_W-1:0] MIN_LAST = LEN_W'(7);

  typedef struct packed {
    logic             offsetEarly;
    logic             polHigh;
    logic             halfMark;
    logic [ACT_W-1:0] actFld;
    logic [LEN_W-1:0] lenFld;
  } fsgCfg_t;

  typedef struct packed {
    logic clear;
    logic load;
    logic step;
  } fsgStrobe_t;
endpackage

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
  import fsg_pkg::*;
#(
  parameter logic [CFG_W-1:0] CFG_RESET = 32'h7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             enable,
  input  logic             bitTick,
  output fsgCfg_t          cfg,
  output fsgStrobe_t       strobe
);
  localparam fsgCfg_t RST_CFG = '{
    offsetEarly: CFG_RESET[OFF_BIT],
    polHigh:     CFG_RESET[POL_BIT],
    halfMark:    CFG_RESET[HALF_BIT],
    actFld:      CFG_RESET[ACT_LSB +: ACT_W],
    lenFld:      CFG_RESET[LEN_LSB +: LEN_W]
  };

  fsgCfg_t wrCfg;
  logic    running;
  logic    unusedBits;

  always_comb begin
    wrCfg.offsetEarly = cfgWrData[OFF_BIT];
    wrCfg.polHigh     = cfgWrData[POL_BIT];
    wrCfg.halfMark    = cfgWrData[HALF_BIT];
    wrCfg.actFld      = cfgWrData[ACT_LSB +: ACT_W];
    wrCfg.lenFld      = cfgWrData[LEN_LSB +: LEN_W];
  end

  assign unusedBits = ^{cfgWrData[CFG_W-1:OFF_BIT+1], cfgWrData[ACT_LSB+ACT_W]};

  // settings are frozen while running
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= RST_CFG;
    end else if (cfgWrEn && !enable) begin
      cfg <= wrCfg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (!enable) begin
      running <= 1'b0;
    end else if (bitTick) begin
      running <= 1'b1;
    end
  end

  always_comb begin
    strobe.clear = !enable;
    strobe.load  = enable && bitTick && !running;
    strobe.step  = enable && bitTick && running;
  end
endmodule

// File: rtl/fsg_datapath.sv
module fsg_datapath
  import fsg_pkg::*;
#(
  parameter logic RESET_IDLE = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  fsgCfg_t          cfg,
  input  fsgStrobe_t       strobe,
  output logic             fsOut,
  output logic [LEN_W-1:0] bitIndex,
  output logic             chanRight,
  output logic             frameStart
);
  logic [LEN_W-1:0] lastIdx;
  logic [CNT_W-1:0] frameLen;
  logic [CNT_W-1:0] halfLen;
  logic [CNT_W-1:0] actLen;
  logic [LEN_W-1:0] nextIdx;
  logic [CNT_W-1:0] nextIdxW;
  logic             active;

  always_comb begin
    lastIdx  = (cfg.lenFld < MIN_LAST) ? MIN_LAST : cfg.lenFld;
    frameLen = {1'b0, lastIdx} + CNT_W'(1);
    halfLen  = frameLen >> 1;
    actLen   = cfg.halfMark ? halfLen : (CNT_W'(cfg.actFld) + CNT_W'(1));
    if (strobe.load || bitIndex >= lastIdx) nextIdx = '0;
    else nextIdx = bitIndex + LEN_W'(1);
    nextIdxW = {1'b0, nextIdx};
    // early mode: window covers the last bit plus the first actLen-1 bits
    if (cfg.offsetEarly) active = (nextIdx == lastIdx) || (nextIdxW + CNT_W'(1) < actLen);
    else                 active = nextIdxW < actLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIndex   <= '0;
      fsOut      <= RESET_IDLE;
      chanRight  <= 1'b0;
      frameStart <= 1'b0;
    end else if (strobe.clear) begin
      bitIndex   <= '0;
      fsOut      <= !cfg.polHigh;
      chanRight  <= 1'b0;
      frameStart <= 1'b0;
    end else if (strobe.load || strobe.step) begin
      bitIndex   <= nextIdx;
      fsOut      <= cfg.polHigh ? active : !active;
      chanRight  <= nextIdxW >= halfLen;
      frameStart <= nextIdx == '0;
    end
  end
endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
  import fsg_pkg::*;
#(
  parameter logic [CFG_W-1:0] CFG_RESET = 32'h7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             enable,
  input  logic             bitTick,
  output logic             fsOut,
  output logic [LEN_W-1:0] bitIndex,
  output logic             chanRight,
  output logic             frameStart
);
  fsgCfg_t    cfg;
  fsgStrobe_t strobe;

  fsg_ctrl #(.CFG_RESET(CFG_RESET)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .enable(enable), .bitTick(bitTick), .cfg(cfg), .strobe(strobe)
  );

  fsg_datapath #(.RESET_IDLE(!CFG_RESET[POL_BIT])) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strobe(strobe),
    .fsOut(fsOut), .bitIndex(bitIndex), .chanRight(chanRight), .frameStart(frameStart)
  );
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker
  import fsg_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             bitTick,
  input logic             fsOut,
  input logic [LEN_W-1:0] bitIndex,
  input logic             chanRight,
  input logic             frameStart
);
  p_start_at_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> bitIndex == '0);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    enable && bitTick |=> (bitIndex == $past(bitIndex) + LEN_W'(1)) || (bitIndex == '0));

  p_hold_between_ticks_r11: assert property (@(posedge clk) disable iff (!rstN)
    enable && !bitTick |=> $stable(bitIndex) && $stable(fsOut) && $stable(chanRight) && $stable(frameStart));

  p_idle_when_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> bitIndex == '0 && !frameStart && !chanRight);

  p_left_at_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    bitIndex == '0 |-> !chanRight);
endmodule

bind frame_sync_gen fsg_checker u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .bitTick(bitTick), .fsOut(fsOut),
  .bitIndex(bitIndex), .chanRight(chanRight), .frameStart(frameStart)
);

// File: tb/frame_sync_gen_bench.sv
module frame_sync_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        enable = 1'b0;
  logic        bitTick = 1'b0;
  logic        fsOut;
  logic [7:0]  bitIndex;
  logic        chanRight;
  logic        frameStart;

  always #10 clk = ~clk;

  frame_sync_gen u_frame_sync_gen (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .enable(enable), .bitTick(bitTick), .fsOut(fsOut), .bitIndex(bitIndex),
    .chanRight(chanRight), .frameStart(frameStart)
  );

  typedef struct {
    int    idx;
    bit    fs;
    bit    chan;
    bit    fst;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t lastExp;
  exp_t monE;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  int mLen = 7, mAct = 0, mHalf = 0, mPol = 0, mOff = 0;
  int mIdx = 0;
  bit mRun = 0;

  task automatic check(string tag, int aIdx, bit aFs, bit aCh, bit aSt,
                       int eIdx, bit eFs, bit eCh, bit eSt);
    nChecks++;
    if (aIdx != eIdx || aFs != eFs || aCh != eCh || aSt != eSt) begin
      nFails++;
      $display("FAIL %s: idx/fs/chan/start actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
               tag, aIdx, aFs, aCh, aSt, eIdx, eFs, eCh, eSt);
    end
  endtask

  function automatic exp_t model(int idx, string tag);
    exp_t e;
    int L = ((mLen < 7) ? 7 : mLen) + 1;
    int half = L / 2;
    int A = mHalf ? half : mAct + 1;
    bit act = mOff ? ((idx == L - 1) || (idx + 1 < A)) : (idx < A);
    e.idx = idx;
    e.fs = mPol ? act : !act;
    e.chan = idx >= half;
    e.fst = idx == 0;
    e.tag = tag;
    return e;
  endfunction

  task automatic writeCfg(logic [31:0] w);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWrData = w;
    if (!enable) begin
      mLen = int'(w[7:0]); mAct = int'(w[14:8]);
      mHalf = int'(w[16]); mPol = int'(w[17]); mOff = int'(w[18]);
    end
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic setEnable(bit v);
    @(negedge clk);
    enable = v;
    if (!v) mRun = 0;
  endtask

  task automatic runTicks(int n, int gap, string tag);
    for (int i = 0; i < n; i++) begin
      int L = ((mLen < 7) ? 7 : mLen) + 1;
      @(negedge clk);
      if (!mRun) begin mRun = 1; mIdx = 0; end
      else mIdx = (mIdx >= L - 1) ? 0 : mIdx + 1;
      lastExp = model(mIdx, tag);
      q.push_back(lastExp);
      bitTick = 1'b1;
      @(negedge clk);
      bitTick = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    if (rstN && bitTick && enable) begin
      #5;
      if (q.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL scoreboard: output with no expected item actual idx %0d expected none", bitIndex);
      end else begin
        monE = q.pop_front();
        check(monE.tag, int'(bitIndex), fsOut, chanRight, frameStart,
              monE.idx, monE.fs, monE.chan, monE.fst);
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset", int'(bitIndex), fsOut, chanRight, frameStart, 0, 1, 0, 0);

    // R1 R2 R3 R4 default settings, ticks with gaps
    setEnable(1);
    runTicks(20, 2, "R1 R2 R3 R4 default");
    // R11 hold between ticks
    repeat (3) @(negedge clk);
    check("R11 hold", int'(bitIndex), fsOut, chanRight, frameStart,
          lastExp.idx, lastExp.fs, lastExp.chan, lastExp.fst);
    setEnable(0);
    @(negedge clk);
    check("R11 idle", int'(bitIndex), fsOut, chanRight, frameStart, 0, 1, 0, 0);

    // R4 R5 active high, 16-bit frame, 4-bit pulse
    writeCfg(32'h0002_030F);
    @(negedge clk);
    check("R5 idle level", int'(bitIndex), fsOut, chanRight, frameStart, 0, 0, 0, 0);
    setEnable(1);
    runTicks(40, 0, "R4 R5 polarity");
    setEnable(0);

    // R2 clamp: length field 3 acts as 7
    writeCfg(32'h0000_0103);
    setEnable(1);
    runTicks(20, 1, "R2 clamp");
    setEnable(0);

    // R6 early shift, 10-bit frame, 3-bit pulse
    writeCfg(32'h0004_0209);
    setEnable(1);
    runTicks(32, 0, "R6 early");
    setEnable(0);

    // R7 R9 half mark, 32-bit frame, early shift, active high
    writeCfg(32'h0007_0A1F);
    setEnable(1);
    runTicks(70, 0, "R7 R9 half mark");
    setEnable(0);

    // R9 odd frame 11 bits
    writeCfg(32'h0001_000A);
    setEnable(1);
    runTicks(25, 0, "R9 odd half");
    setEnable(0);

    // R8 pulse longer than frame
    writeCfg(32'h0002_640F);
    setEnable(1);
    runTicks(36, 0, "R8 long pulse");
    setEnable(0);

    // R10 write while enabled ignored
    writeCfg(32'h0000_0009);
    setEnable(1);
    runTicks(5, 0, "R10 before");
    writeCfg(32'h0006_0013);
    runTicks(20, 0, "R10 while enabled");
    setEnable(0);
    @(negedge clk);
    check("R10 idle level kept", int'(bitIndex), fsOut, chanRight, frameStart, 0, 1, 0, 0);
    setEnable(1);
    runTicks(12, 0, "R10 after re-enable");
    setEnable(0);

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    finishRun();
  end
endmodule